// File: doc/BRIEF.md
# Block Encoder Handshake Controller

This controller sequences one data block at a time through a block-based channel encoder. A configuration strobe loads the block length, checked against the set of lengths that the selected coding mode allows. The controller then accepts input bits under a valid/ready handshake. It withdraws its input-ready flag one cycle before the final bit of the block, and it still takes that final bit. After a mode-dependent latency that does not depend on block length, it presents the encoded stream. A consumer read strobe drains that stream and may stall it at any time.

The stored block, the interleaver and the convolutional encoders are outside this block. They are stood in for by an output stream of `len*OUT_MULT + TAIL_BITS` bits, whose bit value is the parity of the number of bits already read. Once the stream is drained, the controller re-arms for another block of the same length. An active-low asynchronous reset and an active-high synchronous restart both return it to idle. From idle, only a new legal length strobe starts it again.

Top module: `blk_enc_handshake`

## Requirements
- R1: After the asynchronous reset, `in_ready`, `out_ready` and `cfg_err` are low, and they stay low while `in_valid` toggles, until a legal length is strobed in.
- R2: A legal length strobed while idle, or while loading before the first bit of the block is taken, becomes the block length. `in_ready` is high in the next cycle. A bit offered in the same cycle as such a strobe is not taken.
- R3: A strobe at any other time (mid-load, during latency, during output) is ignored. `cfg_err` stays low, and the current and following blocks keep the old length.
- R4: Legal lengths are 40..5114 in mode 0, 378..20730 in mode 1, and exactly 1784, 3568, 7136 or 8920 in mode 2. An illegal strobed length leaves the stored length and the state unchanged, and it raises `cfg_err` for exactly the one cycle after the strobe.
- R5: A bit is taken only in a cycle where `in_valid` is high during loading. `in_valid` low holds the count.
- R6: `in_ready` falls right after L-1 bits of a length-L block are taken. Exactly one more bit with `in_valid` high is then taken. `in_valid` after that has no effect on the block.
- R7: When the last bit is taken in the cycle after `in_ready` falls, `out_ready` rises exactly LAT cycles after `in_ready` fell. LAT is 10 in mode 0, 9 in mode 1 and 12 in mode 2, for every block length.
- R8: The output stream holds `L*OUT_MULT + TAIL_BITS` bits. While `out_ready` is high, `out_bit` equals the number of reads done so far in this block modulo 2. A read advances only when `out_read` and `out_ready` are both high. `out_read` low holds `out_bit`, and `out_read` outside the output phase has no effect.
- R9: After the final read, `out_ready` is low and `in_ready` is high in the next cycle, for a new block of the same length with no strobe.
- R10: A synchronous restart at any point drops both ready flags in the next cycle and clears the stored length. Input is then refused until a new legal strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_rst | input | 1 | Synchronous restart to idle, active high |
| cfg_strobe | input | 1 | Samples `cfg_len` when high |
| cfg_len | input | LEN_W | Requested block length in bits |
| cfg_err | output | 1 | One-cycle flag: last strobed length rejected |
| in_valid | input | 1 | Input bit offered this cycle |
| in_ready | output | 1 | Controller wants more input bits |
| out_ready | output | 1 | Encoded bit available on `out_bit` |
| out_read | input | 1 | Consumer takes the current output bit |
| out_bit | output | 1 | Current encoded output bit |

## Verification
The bench builds three instances side by side, one per coding mode (0, 1 and 2), with the default 15-bit length field, an output multiplier of 3 and a 12-bit tail. This puts all three latencies (10, 9, 12), every legality boundary including the four discrete lengths of mode 2, and full blocks of 40, 64, 378 and 1784 bits within a short run. The same parameters let the bench follow both stalled and streaming handshakes, strobes placed inside and outside the configuration window, and restarts during loading and during output.

// File: rtl/enc_hs_pkg.sv
package enc_hs_pkg;

    // Coding mode: 0 = short-block cellular, 1 = long-block cellular, 2 = 16-state telemetry
    typedef enum logic [1:0] {
        MODE_UMTS  = 2'd0,
        MODE_MCDMA = 2'd1,
        MODE_TLM   = 2'd2
    } enc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOAD    = 2'd1,
        ST_LATENCY = 2'd2,
        ST_OUTPUT  = 2'd3
    } hs_state_e;

    // Per-cycle handshake events
    typedef struct packed {
        logic take_in;
        logic last_in;
        logic take_out;
        logic last_out;
    } hs_evt_t;

    function automatic int unsigned lat_of(enc_mode_e m);
        case (m)
            MODE_MCDMA: return 9;
            MODE_TLM:   return 12;
            default:    return 10;
        endcase
    endfunction

    function automatic int unsigned max_len_of(enc_mode_e m);
        case (m)
            MODE_MCDMA: return 20730;
            MODE_TLM:   return 8920;
            default:    return 5114;
        endcase
    endfunction

    function automatic logic len_ok(enc_mode_e m, int unsigned n);
        case (m)
            MODE_UMTS:  return (n >= 40) && (n <= 5114);
            MODE_MCDMA: return (n >= 378) && (n <= 20730);
            default:    return (n == 1784) || (n == 3568) || (n == 7136) || (n == 8920);
        endcase
    endfunction

endpackage

// File: rtl/enc_hs_tally.sv
module enc_hs_tally #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/enc_hs_lenreg.sv
module enc_hs_lenreg
    import enc_hs_pkg::*;
#(
    parameter enc_mode_e MODE  = MODE_UMTS,
    parameter int        LEN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_rst,
    input  logic             window,
    input  logic             strobe,
    input  logic [LEN_W-1:0] len_in,
    output logic [LEN_W-1:0] len_q,
    output logic             take,
    output logic             err_q
);

    logic legal;

    assign legal = len_ok(MODE, 32'(len_in));
    assign take  = window && strobe && legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            err_q <= 1'b0;
        end else if (sync_rst) begin
            len_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= window && strobe && !legal;
            if (take) begin
                len_q <= len_in;
            end
        end
    end

    AST_REJECT_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (window && strobe && !legal && !sync_rst) |=> (err_q && len_q == $past(len_q))); // R4

endmodule

// File: rtl/blk_enc_handshake.sv
module blk_enc_handshake
    import enc_hs_pkg::*;
#(
    parameter enc_mode_e MODE      = MODE_UMTS,
    parameter int        LEN_W     = 15,
    parameter int        OUT_MULT  = 3,
    parameter int        TAIL_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_rst,
    input  logic             cfg_strobe,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             cfg_err,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             out_ready,
    input  logic             out_read,
    output logic             out_bit
);

    localparam int LAT     = int'(lat_of(MODE));
    localparam int MAX_LEN = int'(max_len_of(MODE));
    localparam int OUT_MAX = MAX_LEN * OUT_MULT + TAIL_BITS;
    localparam int OUT_W   = $clog2(OUT_MAX + 1);
    localparam int LAT_W   = $clog2(LAT + 1);

    hs_state_e        state_q, state_d;
    hs_evt_t          ev;
    logic [LEN_W-1:0] len_q, len_m1, in_cnt;
    logic [OUT_W-1:0] out_cnt, out_len;
    logic [LAT_W-1:0] lat_cnt;
    logic             window, cfg_take, lat_zone, lat_done;

    // Length may be (re)loaded only before any bit of a block is taken
    assign window = (state_q == ST_IDLE) || (state_q == ST_LOAD && in_cnt == '0);

    enc_hs_lenreg #(.MODE(MODE), .LEN_W(LEN_W)) u_lenreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_rst(sync_rst),
        .window  (window),
        .strobe  (cfg_strobe),
        .len_in  (cfg_len),
        .len_q   (len_q),
        .take    (cfg_take),
        .err_q   (cfg_err)
    );

    assign len_m1  = len_q - 1'b1;
    assign out_len = OUT_W'(len_q) * OUT_W'(OUT_MULT) + OUT_W'(TAIL_BITS);

    always_comb begin
        ev.take_in  = (state_q == ST_LOAD) && in_valid && !(window && cfg_strobe);
        ev.last_in  = ev.take_in && (in_cnt == len_m1);
        ev.take_out = (state_q == ST_OUTPUT) && out_read;
        ev.last_out = ev.take_out && (out_cnt == out_len - 1'b1);
    end

    // Latency window opens when input-ready falls, saturates one short of LAT
    assign lat_zone = (state_q == ST_LOAD && in_cnt == len_m1) || (state_q == ST_LATENCY);
    assign lat_done = (lat_cnt == LAT_W'(LAT - 1));

    enc_hs_tally #(.W(LEN_W)) u_in_tally (
        .clk(clk), .rst_n(rst_n),
        .clr(sync_rst || ev.last_out), .inc(ev.take_in), .cnt(in_cnt)
    );

    enc_hs_tally #(.W(OUT_W)) u_out_tally (
        .clk(clk), .rst_n(rst_n),
        .clr(sync_rst || ev.last_out), .inc(ev.take_out), .cnt(out_cnt)
    );

    enc_hs_tally #(.W(LAT_W)) u_lat_tally (
        .clk(clk), .rst_n(rst_n),
        .clr(sync_rst || !lat_zone), .inc(lat_zone && !lat_done), .cnt(lat_cnt)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (cfg_take)    state_d = ST_LOAD;
            ST_LOAD:    if (ev.last_in)  state_d = ST_LATENCY;
            ST_LATENCY: if (lat_done)    state_d = ST_OUTPUT;
            ST_OUTPUT:  if (ev.last_out) state_d = ST_LOAD;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (sync_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign in_ready  = (state_q == ST_LOAD) && (in_cnt < len_m1);
    assign out_ready = (state_q == ST_OUTPUT);
    assign out_bit   = out_ready && out_cnt[0];

    AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !in_valid && !sync_rst) |=> (in_cnt == $past(in_cnt))); // R5

    AST_ONE_MORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !in_ready && in_valid && !sync_rst) |=> (state_q == ST_LATENCY)); // R6

    AST_LAT_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATENCY && lat_done && !sync_rst) |=> out_ready); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !out_read && !sync_rst) |=> (out_ready && out_bit == $past(out_bit))); // R8

    AST_RESTART_SAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.last_out && !sync_rst) |=> (in_ready && in_cnt == '0)); // R9

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rst |=> (!in_ready && !out_ready && len_q == '0)); // R10

endmodule

// File: tb/blk_enc_handshake_bench.sv
module blk_enc_handshake_bench;
    import enc_hs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NM         = 3;
    localparam int LEN_W      = 15;
    localparam int OUT_MULT   = 3;
    localparam int TAIL       = 12;
    localparam int NV         = 14;

    typedef struct packed {
        logic [1:0]  m;
        logic [14:0] len;
        logic        ok;
    } cvec_t;

    // Legality vectors: mode, length, accepted?
    localparam cvec_t CVEC [NV] = '{
        '{2'd0, 15'd39,    1'b0},
        '{2'd0, 15'd5114,  1'b1},
        '{2'd0, 15'd40,    1'b1},
        '{2'd0, 15'd5115,  1'b0},
        '{2'd1, 15'd377,   1'b0},
        '{2'd1, 15'd20730, 1'b1},
        '{2'd1, 15'd20731, 1'b0},
        '{2'd1, 15'd378,   1'b1},
        '{2'd2, 15'd1785,  1'b0},
        '{2'd2, 15'd8920,  1'b1},
        '{2'd2, 15'd3568,  1'b1},
        '{2'd2, 15'd7136,  1'b1},
        '{2'd2, 15'd1000,  1'b0},
        '{2'd2, 15'd1784,  1'b1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sync_rst   [NM];
    logic             cfg_strobe [NM];
    logic [LEN_W-1:0] cfg_len    [NM];
    logic             cfg_err    [NM];
    logic             in_valid   [NM];
    logic             in_ready   [NM];
    logic             out_ready  [NM];
    logic             out_read   [NM];
    logic             out_bit    [NM];
    bit               have_len   [NM];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar i = 0; i < NM; i++) begin : g_dut
        localparam enc_mode_e M = enc_mode_e'(i);
        blk_enc_handshake #(.MODE(M), .LEN_W(LEN_W), .OUT_MULT(OUT_MULT), .TAIL_BITS(TAIL))
        u_blk_enc_handshake (
            .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst[i]),
            .cfg_strobe(cfg_strobe[i]), .cfg_len(cfg_len[i]), .cfg_err(cfg_err[i]),
            .in_valid(in_valid[i]), .in_ready(in_ready[i]),
            .out_ready(out_ready[i]), .out_read(out_read[i]), .out_bit(out_bit[i])
        );
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int lat_exp(input int m);
        return (m == 0) ? 10 : (m == 1) ? 9 : 12;
    endfunction

    task automatic cfg_check(input int m, input int len, input bit ok);
        cfg_strobe[m] = 1'b1;
        cfg_len[m]    = LEN_W'(len);
        in_valid[m]   = 1'b0;
        step();
        cfg_strobe[m] = 1'b0;
        chk("R4", "cfg_err after strobe", int'(cfg_err[m]), ok ? 0 : 1);
        if (ok) have_len[m] = 1'b1;
        chk("R2", "in_ready after strobe", int'(in_ready[m]), have_len[m] ? 1 : 0);
        step();
        chk("R4", "cfg_err lasts one cycle", int'(cfg_err[m]), 0);
    endtask

    task automatic run_block(input int m, input int len, input bit stall_in,
                             input bit stall_out, input bit mid_cfg);
        int acc = 0;
        int n   = 0;
        int s0  = -1;
        int r   = 0;
        int ol  = len * OUT_MULT + TAIL;
        chk("R9", "in_ready at block start", int'(in_ready[m]), 1);
        while (acc < len) begin
            bit v;
            v = !(stall_in && acc > 0 && acc < len - 2 && (n % 4 == 1));
            chk(stall_in ? "R5" : "R6", "in_ready vs bits taken", int'(in_ready[m]), (acc < len - 1) ? 1 : 0);
            chk("R3", "no cfg_err mid-block", int'(cfg_err[m]), 0);
            in_valid[m]   = v;
            cfg_strobe[m] = mid_cfg && acc == 5;
            cfg_len[m]    = LEN_W'(len + 20);
            step();
            n++;
            if (v) acc++;
            if (s0 < 0 && !in_ready[m]) s0 = n;
        end
        cfg_strobe[m] = 1'b0;
        in_valid[m]   = 1'b1;   // extra bits after the last one must be ignored (R6)
        out_read[m]   = 1'b1;   // reads before output must be ignored (R8)
        while (n - s0 < lat_exp(m)) begin
            chk("R7", "out_ready during latency", int'(out_ready[m]), 0);
            step();
            n++;
        end
        chk("R7", "out_ready after fixed latency", int'(out_ready[m]), 1);
        while (r < ol) begin
            bit rd;
            rd = !(stall_out && (n % 3 == 1) && r < ol - 1);
            chk("R8", "out_ready while streaming", int'(out_ready[m]), 1);
            chk("R8", "out_bit parity", int'(out_bit[m]), r % 2);
            chk("R3", "no cfg_err during output", int'(cfg_err[m]), 0);
            out_read[m]   = rd;
            in_valid[m]   = (r < ol - 1);
            cfg_strobe[m] = mid_cfg && r == 3;
            step();
            n++;
            if (rd) r++;
        end
        out_read[m]   = 1'b0;
        in_valid[m]   = 1'b0;
        cfg_strobe[m] = 1'b0;
        chk("R9", "out_ready after final read", int'(out_ready[m]), 0);
        chk("R9", "in_ready for next block", int'(in_ready[m]), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NM; i++) begin
            sync_rst[i] = 1'b0; cfg_strobe[i] = 1'b0; cfg_len[i] = '0;
            in_valid[i] = 1'b0; out_read[i] = 1'b0; have_len[i] = 1'b0;
        end
        repeat (3) step();
        for (int i = 0; i < NM; i++) begin
            chk("R1", "in_ready in reset", int'(in_ready[i]), 0);
            chk("R1", "out_ready in reset", int'(out_ready[i]), 0);
            chk("R1", "cfg_err in reset", int'(cfg_err[i]), 0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < NM; i++) in_valid[i] = 1'b1;
        repeat (4) step();
        for (int i = 0; i < NM; i++) begin
            in_valid[i] = 1'b0;
            chk("R1", "in_ready idle without length", int'(in_ready[i]), 0);
            chk("R1", "out_ready idle without length", int'(out_ready[i]), 0);
        end

        // Legality table, every strobe inside the configuration window
        for (int k = 0; k < NV; k++) begin
            cfg_check(int'(CVEC[k].m), int'(CVEC[k].len), CVEC[k].ok);
        end

        // Blocks in every mode; kept lengths after rejects are 40, 378, 1784
        run_block(0, 40, 1'b0, 1'b0, 1'b0);
        run_block(0, 40, 1'b1, 1'b1, 1'b1);
        run_block(0, 40, 1'b0, 1'b0, 1'b0);
        run_block(1, 378, 1'b0, 1'b0, 1'b1);
        run_block(2, 1784, 1'b0, 1'b1, 1'b0);

        // Reload between blocks (R2)
        cfg_check(0, 64, 1'b1);
        run_block(0, 64, 1'b0, 1'b1, 1'b0);

        // Synchronous restart mid-load (R10)
        in_valid[0] = 1'b1;
        repeat (10) step();
        sync_rst[0] = 1'b1;
        step();
        sync_rst[0] = 1'b0;
        have_len[0] = 1'b0;
        chk("R10", "in_ready after restart", int'(in_ready[0]), 0);
        chk("R10", "out_ready after restart", int'(out_ready[0]), 0);
        repeat (5) step();
        chk("R10", "input refused without strobe", int'(in_ready[0]), 0);
        cfg_check(0, 40, 1'b1);
        run_block(0, 40, 1'b0, 1'b0, 1'b0);

        // Synchronous restart during output (R10)
        in_valid[0] = 1'b1;
        repeat (40) step();
        in_valid[0] = 1'b0;
        repeat (12) step();
        chk("R7", "out_ready after 40-bit block", int'(out_ready[0]), 1);
        out_read[0] = 1'b1;
        repeat (5) step();
        out_read[0] = 1'b0;
        chk("R8", "out_bit after five reads", int'(out_bit[0]), 1);
        sync_rst[0] = 1'b1;
        step();
        sync_rst[0] = 1'b0;
        have_len[0] = 1'b0;
        chk("R10", "out_ready after output restart", int'(out_ready[0]), 0);
        chk("R10", "in_ready after output restart", int'(in_ready[0]), 0);
        cfg_check(0, 40, 1'b1);
        run_block(0, 40, 1'b1, 1'b0, 1'b0);

        // Asynchronous reset mid-load (R1)
        in_valid[0] = 1'b1;
        repeat (10) step();
        #1 rst_n = 1'b0;
        #1 chk("R1", "in_ready drops on async reset", int'(in_ready[0]), 0);
        in_valid[0] = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1", "in_ready after async reset", int'(in_ready[0]), 0);
        chk("R1", "out_ready after async reset", int'(out_ready[0]), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule